// File: doc/BRIEF.md
# 10 Mb/s Manchester Transmit Framer

The framer turns a stream of MAC transmit bits into a Manchester-coded serial line for 10 Mb/s twisted-pair operation. It runs on a clock at twice the bit rate, so every bit time is two clock cycles. One cycle holds the first half of the bit and the next cycle holds the second half.

When the MAC raises its frame request, the framer sends the frame in this order:
- a 62-bit alternating preamble that starts with a 1;
- a two-bit start-of-frame delimiter of two 1s;
- the frame body, fetched one bit at a time through a ready strobe (destination address, source address, length, LLC data and FCS, all supplied by the MAC);
- a start-of-idle marker, which holds the line high for two bit times with no mid-bit edge.

After the marker the line stays low and free of transitions until the next request. The MAC ends the body by dropping its request at the point where the framer would fetch the next bit. A request that is raised during the marker waits until the marker is over, and the next preamble then follows without a gap.

Top module: `mtx_framer`

## Requirements
- R1: During reset and while idle, `line_out` is 0 and `bit_take` is 0.
- R2: Each body bit spans two clocks. A 1 is sent as 0 then 1, and a 0 is sent as 1 then 0.
- R3: A request (`frm_valid`=1) sampled while idle starts the preamble on the next clock. The preamble is 62 Manchester-coded bits that alternate 1,0,1,0 and end with 0, which makes 124 clocks.
- R4: Straight after the preamble, two Manchester-coded 1 bits form the delimiter.
- R5: `bit_take` is 1 only in the second-half clock of the last delimiter bit or of a body bit, and only while `frm_valid` is 1. The `frm_bit` value sampled at that edge is sent as the next body bit.
- R6: If `frm_valid` is 0 where a fetch would happen, the start-of-idle marker follows. The line is held at 1 for four clocks with no edge.
- R7: After the marker, with no request pending, the line is 0 and shows no transitions.
- R8: If `frm_valid` is 1 in the final marker clock, the marker completes in full and the next preamble begins on the following clock.
- R9: During the preamble, the delimiter and the marker, `bit_take` stays 0 and the value of `frm_bit` has no effect on the line.
- R10: If `frm_valid` drops during the preamble or the delimiter, both still complete. The marker then follows the delimiter, so the frame has an empty body.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Frame request from the MAC, and body bits still pending |
| frm_bit | input | 1 | Next body bit from the MAC |
| bit_take | output | 1 | Strobe: `frm_bit` is consumed at this clock edge |
| line_out | output | 1 | Manchester-coded serial output |

## Verification
The hardest case to reach is a request raised during the start-of-idle marker. The marker lasts only four clocks, and it is reached only after a full preamble, delimiter and body. The bench builds its stimulus and its expected waveform together, frame by frame. To chain two frames, it raises the request over the four marker clocks of the first frame and expects the next preamble on the clock right after them. It also drives random `frm_bit` values in every cycle where no fetch is expected. It drops the request in the clock just after a frame starts, to cover the empty-body path.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_SFD  = 3'd2,
    ST_BODY = 3'd3,
    ST_SOI  = 3'd4
  } mtx_st_e;

  // Line level for a data bit in a given half of its bit time
  function automatic logic manch_level(logic data, logic second_half);
    return second_half ? data : ~data;
  endfunction

  // Preamble bit by index parity: even index -> 1, odd index -> 0
  function automatic logic pre_bit(logic idx_lsb);
    return ~idx_lsb;
  endfunction

endpackage

// File: rtl/mtx_seq.sv
module mtx_seq
  import mtx_pkg::*;
#(
  parameter int PRE_BITS = 62,
  parameter int SFD_BITS = 2,
  parameter int SOI_BITS = 2,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  output mtx_st_e          st,
  output logic             half,
  output logic [CNT_W-1:0] cnt,
  output logic             take
);

  logic    last_bit;
  mtx_st_e st_next;

  always_comb begin
    last_bit = 1'b0;
    st_next  = st;
    case (st)
      ST_PRE: begin
        last_bit = (cnt == CNT_W'(PRE_BITS - 1));
        st_next  = ST_SFD;
      end
      ST_SFD: begin
        last_bit = (cnt == CNT_W'(SFD_BITS - 1));
        st_next  = frm_valid ? ST_BODY : ST_SOI;
      end
      ST_BODY: begin
        last_bit = 1'b1;
        st_next  = frm_valid ? ST_BODY : ST_SOI;
      end
      ST_SOI: begin
        last_bit = (cnt == CNT_W'(SOI_BITS - 1));
        st_next  = frm_valid ? ST_PRE : ST_IDLE;
      end
      default: begin
        last_bit = 1'b0;
        st_next  = ST_IDLE;
      end
    endcase
  end

  assign take = half && frm_valid && last_bit &&
                ((st == ST_SFD) || (st == ST_BODY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      half <= 1'b0;
      cnt  <= '0;
    end else if (st == ST_IDLE) begin
      half <= 1'b0;
      cnt  <= '0;
      if (frm_valid) st <= ST_PRE;
    end else begin
      half <= ~half;
      if (half) begin
        if (last_bit) begin
          cnt <= '0;
          st  <= st_next;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mtx_bitsel.sv
module mtx_bitsel
  import mtx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  logic    frm_bit,
  input  mtx_st_e st,
  input  logic    pre_lsb,
  output logic    cur_bit
);

  logic data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= 1'b0;
    else if (take) data_q <= frm_bit;
  end

  always_comb begin
    case (st)
      ST_PRE:  cur_bit = pre_bit(pre_lsb);
      ST_SFD:  cur_bit = 1'b1;
      ST_BODY: cur_bit = data_q;
      default: cur_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/mtx_enc.sv
module mtx_enc
  import mtx_pkg::*;
(
  input  mtx_st_e st,
  input  logic    half,
  input  logic    cur_bit,
  output logic    line
);

  always_comb begin
    case (st)
      ST_IDLE: line = 1'b0;
      ST_SOI:  line = 1'b1;
      default: line = manch_level(cur_bit, half);
    endcase
  end

endmodule

// File: rtl/mtx_framer.sv
module mtx_framer
  import mtx_pkg::*;
#(
  parameter int PRE_BITS = 62,
  parameter int SFD_BITS = 2,
  parameter int SOI_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_valid,
  input  logic frm_bit,
  output logic bit_take,
  output logic line_out
);

  localparam int CNT_W = $clog2(PRE_BITS + SFD_BITS + SOI_BITS);

  mtx_st_e          st_w;
  logic             half_w;
  logic [CNT_W-1:0] cnt_w;
  logic             take_w;
  logic             cur_bit_w;
  logic             line_w;

  mtx_seq #(
    .PRE_BITS(PRE_BITS),
    .SFD_BITS(SFD_BITS),
    .SOI_BITS(SOI_BITS),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_valid(frm_valid),
    .st       (st_w),
    .half     (half_w),
    .cnt      (cnt_w),
    .take     (take_w)
  );

  mtx_bitsel u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take_w),
    .frm_bit(frm_bit),
    .st     (st_w),
    .pre_lsb(cnt_w[0]),
    .cur_bit(cur_bit_w)
  );

  mtx_enc u_enc (
    .st     (st_w),
    .half   (half_w),
    .cur_bit(cur_bit_w),
    .line   (line_w)
  );

  assign bit_take = take_w;
  assign line_out = line_w;

endmodule

// File: rtl/mtx_chk.sv
module mtx_chk
  import mtx_pkg::*;
#(
  parameter int PRE_BITS = 62,
  parameter int SOI_BITS = 2,
  parameter int CNT_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input mtx_st_e          st,
  input logic             half,
  input logic [CNT_W-1:0] cnt,
  input logic             take,
  input logic             line_out
);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!line_out && !take));

  p_mid_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half && (st inside {ST_PRE, ST_SFD, ST_BODY})) |-> (line_out != $past(line_out)));

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |-> (cnt < CNT_W'(PRE_BITS)));

  p_sfd_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SFD) && ($past(st) != ST_SFD)) |-> ($past(st) == ST_PRE));

  p_take_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((st == ST_BODY) && !half));

  p_soi_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SOI) |-> line_out);

  p_soi_flat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SOI) && half) |-> $stable(line_out));

  p_held_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SOI) && half && (cnt == CNT_W'(SOI_BITS - 1)) && frm_valid)
      |=> ((st == ST_PRE) && !half && (cnt == '0)));

  p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {ST_PRE, ST_SOI}) |-> !take);

endmodule

bind mtx_framer mtx_chk #(
  .PRE_BITS(PRE_BITS),
  .SOI_BITS(SOI_BITS),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frm_valid(frm_valid),
  .st       (st_w),
  .half     (half_w),
  .cnt      (cnt_w),
  .take     (take_w),
  .line_out (line_out)
);

// File: tb/sim_mtx_framer.sv
module sim_mtx_framer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic frm_bit = 1'b0;
  logic bit_take;
  logic line_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mtx_framer u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_valid(frm_valid),
    .frm_bit  (frm_bit),
    .bit_take (bit_take),
    .line_out (line_out)
  );

  // Per-cycle stimulus and expected values
  bit    qv[$];
  bit    qb[$];
  bit    ql[$];
  bit    qt[$];
  string qr[$];

  function automatic bit rnd();
    return 1'($urandom() % 2);
  endfunction

  task automatic push(bit v, bit b, bit l, bit t, string r);
    qv.push_back(v); qb.push_back(b); ql.push_back(l);
    qt.push_back(t); qr.push_back(r);
  endtask

  task automatic add_idle(int n);
    for (int i = 0; i < n; i++) push(1'b0, rnd(), 1'b0, 1'b0, "R7");
  endtask

  task automatic add_frame(bit body[$], bit early, bit chained);
    bit has;
    if (chained) begin
      for (int i = qv.size() - 4; i < qv.size(); i++) begin
        qv[i] = 1'b1;
        qr[i] = "R8";
      end
    end else begin
      push(1'b1, rnd(), 1'b0, 1'b0, "R1");
    end
    for (int i = 0; i < 62; i++) begin
      bit pb;
      pb = (i % 2 == 0);
      push(!early, rnd(), !pb, 1'b0, early ? "R10" : "R3 R9");
      push(!early, rnd(), pb, 1'b0, early ? "R10" : "R3 R9");
    end
    has = (body.size() > 0);
    push(!early, rnd(), 1'b0, 1'b0, "R4");
    push(!early, rnd(), 1'b1, 1'b0, "R4");
    push(!early, rnd(), 1'b0, 1'b0, "R4");
    push(has, has ? body[0] : rnd(), 1'b1, has, "R4 R5");
    for (int k = 0; k < body.size(); k++) begin
      bit more;
      more = (k + 1 < body.size());
      push(1'b1, rnd(), !body[k], 1'b0, "R2");
      push(more, more ? body[k+1] : rnd(), body[k], more, "R5");
    end
    for (int i = 0; i < 4; i++) push(1'b0, rnd(), 1'b1, 1'b0, "R6");
  endtask

  task automatic chk(bit act, bit exp, string what, string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit body_a[$];
    bit body_b[$];
    bit body_c[$];
    bit body_e[$];
    bit none[$];

    for (int i = 0; i < 16; i++) body_a.push_back(rnd());
    body_b.push_back(1'b1);
    body_c = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 8; i++) body_e.push_back(1'b0);

    add_idle(5);
    add_frame(body_a, 1'b0, 1'b0);
    add_idle(3);
    add_frame(body_b, 1'b0, 1'b0);
    add_frame(body_c, 1'b0, 1'b1);
    add_idle(4);
    add_frame(none, 1'b1, 1'b0);
    add_idle(6);
    add_frame(body_e, 1'b0, 1'b0);
    add_idle(5);

    // R1: reset state, with the request held high during reset
    frm_valid = 1'b1;
    frm_bit   = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      chk(line_out, 1'b0, "line in reset", "R1");
      chk(bit_take, 1'b0, "take in reset", "R1");
    end
    @(negedge clk);
    frm_valid = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < qv.size(); i++) begin
      @(negedge clk);
      frm_valid = qv[i];
      frm_bit   = qb[i];
      #1;
      chk(line_out, ql[i], $sformatf("line cycle %0d", i), qr[i]);
      chk(bit_take, qt[i], $sformatf("take cycle %0d", i), qr[i]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule